// File: doc/BRIEF.md
# Kernel Mode Access Monitor

This block watches a processor's fetch, data, interrupt-entry and interrupt-return activity and decides, cycle by cycle, whether the core is running privileged kernel code or ordinary user code. Privilege is gained only by reaching one fixed entry address on one fixed program overlay page, and it is lost again when execution branches out of the kernel program region. While the core runs user code, any touch of the protected program or data regions is a violation.

Interrupts are tracked with a single saved return point. When kernel code is interrupted by a handler at an unprotected vector, the interrupted address and overlay page are stored. The handler may call back into the kernel once, which gives the nested state. The eventual return from interrupt must land on exactly the stored point. Interrupts to protected vectors leave the core in kernel mode and are not counted.

Every violation results in a chip reset, never a trap. A registered reset pulse of fixed length is raised. An erase strobe is raised in the first cycle of that pulse. All tracking state returns to user mode. The monitor has no means to stall the core, so every event input is a plain one-cycle strobe with no ready or back-pressure path. Each strobe is accepted in the cycle it is high, unless a reset pulse is in progress.

Top module: `kmode_guard`

## Requirements
- R1: A fetch of address 0x2000 with program overlay 0x000F puts the block in kernel mode from the next cycle. From the plain user state it gives kmode=1, nested=0. From an interrupt handler that suspended the kernel it gives kmode=1, nested=1.
- R2: In user mode, a fetch is a violation if its address is in 0x2001..0x3FFF, or if its overlay is in 0x000C..0x000F, except for the exact entry point of R1. Fetches of 0x0000..0x2000 on overlays 0x0000..0x000B are allowed.
- R3: In user mode, a data access is a violation if its address is in 0x0000..0x17FF or its data overlay is 0x000F. In kernel mode, no data access is checked.
- R4: Kernel space is address 0x2000..0x3FFF together with overlay 0x000C..0x000F. A kernel fetch outside that space gives kmode=0 on the next cycle, with no violation. If the block was nested, it returns to the suspended handler state (nested=0, ksusp=1).
- R5: The cycle after a violation, viol_rst is high for exactly RST_CYC cycles (default 4). erase_req is high only in the first of those cycles. kmode, nested and ksusp clear, and the saved return point is discarded. Strobes that arrive while viol_rst is high have no effect.
- R6: An interrupt strobe with a vector below 0x2000, taken in the kernel state that is not nested, gives kmode=0 and ksusp=1 on the next cycle. It also stores irq_ret_addr and irq_ret_ovl as the return point.
- R7: A return strobe taken in the suspended handler state leads back to kernel mode (kmode=1, nested=0, ksusp=0) when its address and overlay both equal the stored return point. Any difference in either field is a violation. The stored point is unchanged while nested.
- R8: An interrupt strobe with a vector below 0x2000 while nested is a violation.
- R9: An interrupt to a vector at or above 0x2000 taken in kernel mode changes no output, however many are taken. A return strobe in kernel mode also changes no output.
- R10: While rst_n is low, and after it is released, kmode, nested, ksusp, viol_rst and erase_req are all 0.
- R11: In the plain user state, interrupt and return strobes change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_vld | input | 1 | Instruction fetch strobe |
| fetch_addr | input | 14 | Fetch program address |
| fetch_ovl | input | 16 | Program overlay page of the fetch |
| data_vld | input | 1 | Data access strobe |
| data_addr | input | 14 | Data address |
| data_ovl | input | 16 | Data overlay page of the access |
| irq_vld | input | 1 | Interrupt vector entry strobe |
| irq_vec | input | 14 | Vector address being entered |
| irq_ret_addr | input | 14 | Address interrupted by this interrupt |
| irq_ret_ovl | input | 16 | Overlay page interrupted by this interrupt |
| rti_vld | input | 1 | Return-from-interrupt strobe |
| rti_addr | input | 14 | Return target address |
| rti_ovl | input | 16 | Return target overlay page |
| kmode | output | 1 | 1 while in kernel mode |
| nested | output | 1 | 1 while in kernel re-entered from a handler |
| ksusp | output | 1 | 1 while a kernel return point is stored |
| viol_rst | output | 1 | Chip reset pulse after a violation |
| erase_req | output | 1 | One-cycle request to erase sensitive state |

## Verification
The assertions that predict a transition assume that only one strobe is active in the cycle they examine. For that reason each such property requires the other strobes to be low, and a cycle with several strobes is treated only by the violation checks. They also assume that the core raises no strobe it expects to take effect while viol_rst is high. The properties are therefore gated on viol_rst being low. The stimulus raises exactly one strobe per cycle. Strobes are raised during a reset pulse only in the directed test that shows they are ignored.

// File: rtl/kmg_pkg.sv
package kmg_pkg;

  // Tracking states of the monitor
  typedef enum logic [1:0] {
    ST_USER = 2'd0,  // plain user code
    ST_KERN = 2'd1,  // kernel code
    ST_SUSP = 2'd2,  // user handler, kernel return point held
    ST_NEST = 2'd3   // kernel re-entered from that handler
  } kstate_e;

  // Classification of one fetch address / overlay pair
  typedef struct packed {
    logic entry;   // exact legal entry point
    logic kspace;  // inside kernel program space
    logic uprot;   // touches protected program space
  } fetch_cls_t;

endpackage

// File: rtl/kmg_decode.sv
module kmg_decode
  import kmg_pkg::*;
#(
  parameter int AW = 14,
  parameter int OW = 16,
  parameter logic [AW-1:0] KBASE   = 14'h2000,
  parameter logic [OW-1:0] KOVL_LO = 16'h000C,
  parameter logic [OW-1:0] KOVL_HI = 16'h000F,
  parameter logic [AW-1:0] DTOP    = 14'h17FF,
  parameter logic [OW-1:0] DOVL    = 16'h000F
) (
  input  logic [AW-1:0] fetch_addr,
  input  logic [OW-1:0] fetch_ovl,
  input  logic [AW-1:0] data_addr,
  input  logic [OW-1:0] data_ovl,
  input  logic [AW-1:0] irq_vec,
  input  logic [AW-1:0] rti_addr,
  input  logic [OW-1:0] rti_ovl,
  input  logic [AW-1:0] sav_addr,
  input  logic [OW-1:0] sav_ovl,
  output fetch_cls_t    fcls,
  output logic          d_prot,
  output logic          v_prot,
  output logic          rti_hit
);

  logic ovl_kern;

  always_comb begin
    ovl_kern    = (fetch_ovl >= KOVL_LO) && (fetch_ovl <= KOVL_HI);
    fcls.entry  = (fetch_addr == KBASE) && (fetch_ovl == KOVL_HI);
    fcls.kspace = (fetch_addr >= KBASE) && ovl_kern;
    fcls.uprot  = (fetch_addr > KBASE) || ovl_kern;
    d_prot      = (data_addr <= DTOP) || (data_ovl == DOVL);
    v_prot      = (irq_vec >= KBASE);
    rti_hit     = (rti_addr == sav_addr) && (rti_ovl == sav_ovl);
  end

endmodule

// File: rtl/kmg_fsm.sv
module kmg_fsm
  import kmg_pkg::*;
#(
  parameter int AW = 14,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          fetch_vld,
  input  logic          data_vld,
  input  logic          irq_vld,
  input  logic          rti_vld,
  input  fetch_cls_t    fcls,
  input  logic          d_prot,
  input  logic          v_prot,
  input  logic          rti_hit,
  input  logic [AW-1:0] irq_ret_addr,
  input  logic [OW-1:0] irq_ret_ovl,
  output kstate_e       state,
  output logic [AW-1:0] sav_addr,
  output logic [OW-1:0] sav_ovl,
  output logic          viol
);

  kstate_e st_nxt;
  logic    in_user;
  logic    do_save;
  logic    bad_fetch, bad_data, bad_irq, bad_rti;

  // Violation detection: every strobe is examined, whatever the others do
  always_comb begin
    in_user   = (state == ST_USER) || (state == ST_SUSP);
    bad_fetch = in_user && fetch_vld && fcls.uprot && !fcls.entry;
    bad_data  = in_user && data_vld && d_prot;
    bad_irq   = (state == ST_NEST) && irq_vld && !v_prot;
    bad_rti   = (state == ST_SUSP) && rti_vld && !rti_hit;
    viol      = !busy && (bad_fetch || bad_data || bad_irq || bad_rti);
  end

  // Legal transitions: interrupt, then return, then fetch
  always_comb begin
    st_nxt  = state;
    do_save = 1'b0;
    if (irq_vld) begin
      if ((state == ST_KERN) && !v_prot) begin
        st_nxt  = ST_SUSP;
        do_save = 1'b1;
      end
    end else if (rti_vld) begin
      if ((state == ST_SUSP) && rti_hit) st_nxt = ST_KERN;
    end else if (fetch_vld) begin
      unique case (state)
        ST_USER: if (fcls.entry)   st_nxt = ST_KERN;
        ST_SUSP: if (fcls.entry)   st_nxt = ST_NEST;
        ST_KERN: if (!fcls.kspace) st_nxt = ST_USER;
        ST_NEST: if (!fcls.kspace) st_nxt = ST_SUSP;
        default: st_nxt = ST_USER;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_USER;
      sav_addr <= '0;
      sav_ovl  <= '0;
    end else if (viol) begin
      state    <= ST_USER;
      sav_addr <= '0;
      sav_ovl  <= '0;
    end else if (!busy) begin
      state <= st_nxt;
      if (do_save) begin
        sav_addr <= irq_ret_addr;
        sav_ovl  <= irq_ret_ovl;
      end
    end
  end

endmodule

// File: rtl/kmg_pulse.sv
module kmg_pulse #(
  parameter int RST_CYC = 4,
  localparam int CW = $clog2(RST_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic viol_rst,
  output logic erase_req
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      erase_req <= 1'b0;
    end else begin
      erase_req <= trig;
      if (trig)             cnt <= CW'(RST_CYC);
      else if (cnt != '0)   cnt <= cnt - CW'(1);
    end
  end

  assign viol_rst = (cnt != '0);

endmodule

// File: rtl/kmode_guard.sv
module kmode_guard
  import kmg_pkg::*;
#(
  parameter int AW = 14,
  parameter int OW = 16,
  parameter int RST_CYC = 4,
  parameter logic [AW-1:0] KBASE   = 14'h2000,
  parameter logic [OW-1:0] KOVL_LO = 16'h000C,
  parameter logic [OW-1:0] KOVL_HI = 16'h000F,
  parameter logic [AW-1:0] DTOP    = 14'h17FF,
  parameter logic [OW-1:0] DOVL    = 16'h000F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_vld,
  input  logic [AW-1:0] fetch_addr,
  input  logic [OW-1:0] fetch_ovl,
  input  logic          data_vld,
  input  logic [AW-1:0] data_addr,
  input  logic [OW-1:0] data_ovl,
  input  logic          irq_vld,
  input  logic [AW-1:0] irq_vec,
  input  logic [AW-1:0] irq_ret_addr,
  input  logic [OW-1:0] irq_ret_ovl,
  input  logic          rti_vld,
  input  logic [AW-1:0] rti_addr,
  input  logic [OW-1:0] rti_ovl,
  output logic          kmode,
  output logic          nested,
  output logic          ksusp,
  output logic          viol_rst,
  output logic          erase_req
);

  fetch_cls_t    fcls;
  logic          d_prot, v_prot, rti_hit, viol;
  kstate_e       state;
  logic [AW-1:0] sav_addr;
  logic [OW-1:0] sav_ovl;

  kmg_decode #(
    .AW(AW), .OW(OW), .KBASE(KBASE), .KOVL_LO(KOVL_LO),
    .KOVL_HI(KOVL_HI), .DTOP(DTOP), .DOVL(DOVL)
  ) u_decode (
    .fetch_addr(fetch_addr), .fetch_ovl(fetch_ovl),
    .data_addr(data_addr),   .data_ovl(data_ovl),
    .irq_vec(irq_vec),       .rti_addr(rti_addr), .rti_ovl(rti_ovl),
    .sav_addr(sav_addr),     .sav_ovl(sav_ovl),
    .fcls(fcls), .d_prot(d_prot), .v_prot(v_prot), .rti_hit(rti_hit)
  );

  kmg_fsm #(.AW(AW), .OW(OW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .busy(viol_rst),
    .fetch_vld(fetch_vld), .data_vld(data_vld),
    .irq_vld(irq_vld), .rti_vld(rti_vld),
    .fcls(fcls), .d_prot(d_prot), .v_prot(v_prot), .rti_hit(rti_hit),
    .irq_ret_addr(irq_ret_addr), .irq_ret_ovl(irq_ret_ovl),
    .state(state), .sav_addr(sav_addr), .sav_ovl(sav_ovl), .viol(viol)
  );

  kmg_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(viol),
    .viol_rst(viol_rst), .erase_req(erase_req)
  );

  assign kmode  = (state == ST_KERN) || (state == ST_NEST);
  assign nested = (state == ST_NEST);
  assign ksusp  = (state == ST_SUSP) || (state == ST_NEST);

endmodule

// File: rtl/kmg_checker.sv
module kmg_checker #(
  parameter int AW = 14,
  parameter int OW = 16,
  parameter int RST_CYC = 4,
  parameter logic [AW-1:0] KBASE   = 14'h2000,
  parameter logic [OW-1:0] KOVL_LO = 16'h000C,
  parameter logic [OW-1:0] KOVL_HI = 16'h000F,
  parameter logic [AW-1:0] DTOP    = 14'h17FF,
  parameter logic [OW-1:0] DOVL    = 16'h000F,
  localparam int QW = $clog2(RST_CYC + 1) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_vld,
  input logic [AW-1:0] fetch_addr,
  input logic [OW-1:0] fetch_ovl,
  input logic          data_vld,
  input logic [AW-1:0] data_addr,
  input logic [OW-1:0] data_ovl,
  input logic          irq_vld,
  input logic [AW-1:0] irq_vec,
  input logic          rti_vld,
  input logic          kmode,
  input logic          nested,
  input logic          viol_rst,
  input logic          erase_req
);

  logic [QW-1:0] hi_cnt;
  logic          only_fetch;
  logic          fovl_k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_cnt <= '0;
    else if (viol_rst) hi_cnt <= hi_cnt + QW'(1);
    else               hi_cnt <= '0;
  end

  assign only_fetch = fetch_vld && !data_vld && !irq_vld && !rti_vld && !viol_rst;
  assign fovl_k     = (fetch_ovl >= KOVL_LO) && (fetch_ovl <= KOVL_HI);

  a_r1_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (!kmode && only_fetch && fetch_addr == KBASE && fetch_ovl == KOVL_HI) |=> kmode);

  a_r2_prog_viol: assert property (@(posedge clk) disable iff (!rst_n)
    (!kmode && !viol_rst && fetch_vld && (fetch_addr > KBASE ||
      (fovl_k && fetch_ovl != KOVL_HI) || (fovl_k && fetch_addr != KBASE))) |=> viol_rst);

  a_r3_data_viol: assert property (@(posedge clk) disable iff (!rst_n)
    (!kmode && !viol_rst && data_vld && (data_addr <= DTOP || data_ovl == DOVL)) |=> viol_rst);

  a_r4_branch_out: assert property (@(posedge clk) disable iff (!rst_n)
    (kmode && only_fetch && (fetch_addr < KBASE || !fovl_k)) |=> (!kmode && !viol_rst));

  a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(viol_rst) |-> (hi_cnt == QW'(RST_CYC)));

  a_r5_pulse_max: assert property (@(posedge clk) disable iff (!rst_n)
    viol_rst |-> (hi_cnt < QW'(RST_CYC)));

  a_r5_erase_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_rst) |-> erase_req);

  a_r5_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |=> !erase_req);

  a_r5_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    viol_rst |-> (!kmode && !nested));

  a_r8_nest_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (nested && irq_vld && !viol_rst && irq_vec < KBASE) |=> viol_rst);

  a_r1_nest_in_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    nested |-> kmode);

endmodule

bind kmode_guard kmg_checker u_kmg_checker (.*);

// File: tb/kmode_guard_bench.sv
module kmode_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC = 4;
  localparam int NV = 40;

  typedef struct packed {
    logic [1:0]  kind;  // 0 fetch, 1 data, 2 irq, 3 rti
    logic [13:0] a;
    logic [15:0] o;
    logic [13:0] ra;
    logic [15:0] ro;
    logic [3:0]  exp;   // {kmode, nested, ksusp, viol_rst}
    logic [3:0]  req;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{2'd0, 14'h1FFF, 16'h0000, 14'h0, 16'h0, 4'b0000, 4'd2},  // R2 low side allowed
    '{2'd0, 14'h2000, 16'h0000, 14'h0, 16'h0, 4'b0000, 4'd2},  // R2
    '{2'd0, 14'h2000, 16'h000B, 14'h0, 16'h0, 4'b0000, 4'd2},  // R2 overlay just below
    '{2'd1, 14'h1800, 16'h0000, 14'h0, 16'h0, 4'b0000, 4'd3},  // R3 above data range
    '{2'd1, 14'h2000, 16'h000E, 14'h0, 16'h0, 4'b0000, 4'd3},  // R3
    '{2'd2, 14'h0004, 16'h0000, 14'h0, 16'h0, 4'b0000, 4'd11}, // R11
    '{2'd0, 14'h2000, 16'h000F, 14'h0, 16'h0, 4'b1000, 4'd1},  // R1 entry
    '{2'd1, 14'h0000, 16'h000F, 14'h0, 16'h0, 4'b1000, 4'd3},  // R3 kernel free
    '{2'd0, 14'h3FFF, 16'h000C, 14'h0, 16'h0, 4'b1000, 4'd4},  // R4 still kernel
    '{2'd2, 14'h2040, 16'h0000, 14'h0, 16'h0, 4'b1000, 4'd9},  // R9
    '{2'd3, 14'h1234, 16'h0000, 14'h0, 16'h0, 4'b1000, 4'd9},  // R9
    '{2'd0, 14'h1FFF, 16'h000F, 14'h0, 16'h0, 4'b0000, 4'd4},  // R4 branch out
    '{2'd0, 14'h2000, 16'h000F, 14'h0, 16'h0, 4'b1000, 4'd1},  // R1
    '{2'd0, 14'h2100, 16'h0003, 14'h0, 16'h0, 4'b0000, 4'd4},  // R4 overlay out
    '{2'd0, 14'h2000, 16'h000F, 14'h0, 16'h0, 4'b1000, 4'd1},  // R1
    '{2'd2, 14'h0010, 16'h0000, 14'h2345, 16'h000D, 4'b0010, 4'd6}, // R6
    '{2'd0, 14'h0010, 16'h0000, 14'h0, 16'h0, 4'b0010, 4'd6},  // R6 handler runs
    '{2'd0, 14'h2000, 16'h000F, 14'h0, 16'h0, 4'b1110, 4'd1},  // R1 nested entry
    '{2'd2, 14'h2050, 16'h0000, 14'h0, 16'h0, 4'b1110, 4'd9},  // R9 protected vector
    '{2'd0, 14'h0020, 16'h0000, 14'h0, 16'h0, 4'b0010, 4'd4},  // R4 back to handler
    '{2'd3, 14'h2345, 16'h000D, 14'h0, 16'h0, 4'b1000, 4'd7},  // R7 match
    '{2'd2, 14'h0008, 16'h0000, 14'h2222, 16'h000F, 4'b0010, 4'd6}, // R6
    '{2'd3, 14'h2223, 16'h000F, 14'h0, 16'h0, 4'b0001, 4'd7},  // R7 address off
    '{2'd0, 14'h2000, 16'h000F, 14'h0, 16'h0, 4'b1000, 4'd1},  // R1
    '{2'd2, 14'h0004, 16'h0000, 14'h2300, 16'h000E, 4'b0010, 4'd6}, // R6
    '{2'd3, 14'h2300, 16'h000F, 14'h0, 16'h0, 4'b0001, 4'd7},  // R7 overlay off
    '{2'd0, 14'h2000, 16'h000F, 14'h0, 16'h0, 4'b1000, 4'd1},  // R1
    '{2'd2, 14'h0004, 16'h0000, 14'h2001, 16'h000F, 4'b0010, 4'd6}, // R6
    '{2'd0, 14'h2000, 16'h000F, 14'h0, 16'h0, 4'b1110, 4'd1},  // R1
    '{2'd2, 14'h0004, 16'h0000, 14'h0, 16'h0, 4'b0001, 4'd8},  // R8
    '{2'd0, 14'h2001, 16'h0000, 14'h0, 16'h0, 4'b0001, 4'd2},  // R2 lower bound
    '{2'd0, 14'h3FFF, 16'h0000, 14'h0, 16'h0, 4'b0001, 4'd2},  // R2 upper bound
    '{2'd0, 14'h0000, 16'h000C, 14'h0, 16'h0, 4'b0001, 4'd2},  // R2 overlay low
    '{2'd0, 14'h1FFF, 16'h000F, 14'h0, 16'h0, 4'b0001, 4'd2},  // R2 overlay high
    '{2'd0, 14'h2000, 16'h000C, 14'h0, 16'h0, 4'b0001, 4'd2},  // R2 not entry
    '{2'd1, 14'h17FF, 16'h0000, 14'h0, 16'h0, 4'b0001, 4'd3},  // R3 top
    '{2'd1, 14'h0000, 16'h0001, 14'h0, 16'h0, 4'b0001, 4'd3},  // R3 bottom
    '{2'd1, 14'h3000, 16'h000F, 14'h0, 16'h0, 4'b0001, 4'd3},  // R3 overlay
    '{2'd1, 14'h1FFF, 16'h000E, 14'h0, 16'h0, 4'b0000, 4'd3},  // R3 allowed
    '{2'd3, 14'h0100, 16'h0000, 14'h0, 16'h0, 4'b0000, 4'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_vld = 1'b0, data_vld = 1'b0, irq_vld = 1'b0, rti_vld = 1'b0;
  logic [13:0] fetch_addr = '0, data_addr = '0, irq_vec = '0, irq_ret_addr = '0, rti_addr = '0;
  logic [15:0] fetch_ovl = '0, data_ovl = '0, irq_ret_ovl = '0, rti_ovl = '0;
  logic        kmode, nested, ksusp, viol_rst, erase_req;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  kmode_guard u_kmode_guard (
    .clk(clk), .rst_n(rst_n),
    .fetch_vld(fetch_vld), .fetch_addr(fetch_addr), .fetch_ovl(fetch_ovl),
    .data_vld(data_vld), .data_addr(data_addr), .data_ovl(data_ovl),
    .irq_vld(irq_vld), .irq_vec(irq_vec),
    .irq_ret_addr(irq_ret_addr), .irq_ret_ovl(irq_ret_ovl),
    .rti_vld(rti_vld), .rti_addr(rti_addr), .rti_ovl(rti_ovl),
    .kmode(kmode), .nested(nested), .ksusp(ksusp),
    .viol_rst(viol_rst), .erase_req(erase_req)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (kmode,nested,ksusp,viol_rst,erase_req)",
               tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    case (v.kind)
      2'd0: begin fetch_vld = 1'b1; fetch_addr = v.a; fetch_ovl = v.o; end
      2'd1: begin data_vld = 1'b1; data_addr = v.a; data_ovl = v.o; end
      2'd2: begin irq_vld = 1'b1; irq_vec = v.a; irq_ret_addr = v.ra; irq_ret_ovl = v.ro; end
      default: begin rti_vld = 1'b1; rti_addr = v.a; rti_ovl = v.o; end
    endcase
    @(posedge clk);
    @(negedge clk);
    fetch_vld = 1'b0; data_vld = 1'b0; irq_vld = 1'b0; rti_vld = 1'b0;
  endtask

  function automatic logic [4:0] outs();
    return {kmode, nested, ksusp, viol_rst, erase_req};
  endfunction

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10 in reset", outs(), 5'b00000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", outs(), 5'b00000);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      check($sformatf("R%0d vector %0d", TBL[i].req, i), outs(),
            {TBL[i].exp, TBL[i].exp[0]});
      if (TBL[i].exp[0]) begin
        // R5: pulse length and single erase cycle
        for (int c = 1; c < RST_CYC; c++) begin
          @(negedge clk);
          check($sformatf("R5 pulse cycle %0d after vector %0d", c + 1, i), outs(), 5'b00010);
        end
        @(negedge clk);
        check($sformatf("R5 pulse end after vector %0d", i), outs(), 5'b00000);
      end
    end

    // R5: strobes during the pulse are ignored
    apply('{2'd0, 14'h2001, 16'h0000, 14'h0, 16'h0, 4'b0001, 4'd5});
    check("R5 trigger", outs(), 5'b00011);
    fetch_vld = 1'b1; fetch_addr = 14'h2000; fetch_ovl = 16'h000F;
    while (viol_rst) @(negedge clk);
    fetch_vld = 1'b0;
    check("R5 entry during pulse ignored", outs(), 5'b00000);

    // R10: asynchronous reset while nested
    apply('{2'd0, 14'h2000, 16'h000F, 14'h0, 16'h0, 4'b1000, 4'd1});
    apply('{2'd2, 14'h0004, 16'h0000, 14'h2100, 16'h000C, 4'b0010, 4'd6});
    apply('{2'd0, 14'h2000, 16'h000F, 14'h0, 16'h0, 4'b1110, 4'd1});
    check("R1 nested before reset", outs(), 5'b11100);
    rst_n = 1'b0;
    #1;
    check("R10 reset while nested", outs(), 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: return point was discarded by reset, so the old point is no longer in force
    apply('{2'd3, 14'h2100, 16'h000C, 14'h0, 16'h0, 4'b0000, 4'd11});
    check("R11 return after reset is ignored", outs(), 5'b00000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule